// File: doc/BRIEF.md
# Slot-Scheduled Shared SRAM Arbiter

This block lets four slow cable-side data channels and one fast host port share a single 32-bit external static RAM. The arbiter does not arbitrate on request. A free-running slot counter walks a fixed frame of eight slots. Every even slot belongs to the host. Odd slot 2k+1 belongs to channel k. This gives the host half of all memory cycles. It also gives every channel a known worst-case wait of eight cycles.

A cable packet cannot be paused once it has started to arrive. For that reason each channel writes into a small staging FIFO, which accepts a word in any cycle. In its own slot, the channel moves one staged word into its private region of the memory. Each region is a quarter of the lower half of the address space, addressed as {0, channel, offset}. If a channel's FIFO is empty, the same slot can serve a sequential read from that region instead. The host can reach any word in the memory.

All memory pins are driven from registers one cycle after the slot decision. The data bus is split into separate write and read vectors. Read data comes back two cycles after the slot decision.

Top module: `sram_slot_sched`

## Requirements
- R1: While reset is asserted and right after it, sram_we_n and sram_oe_n are high, host_gnt, host_rvalid and every ch_rd_valid bit are low, and every ch_ovf bit is 0.
- R2: The first cycle after reset is slot 0. Slot s = cycle count mod 2*NCH. Even slots belong to the host, and slot 2k+1 belongs to channel k. host_gnt is high only in a host slot in which host_req is high, and a memory access only ever serves the owner of its slot.
- R3: A channel write goes to word address {1'b0, channel[CH_W-1:0], offset[OFF_W-1:0]}. Offsets start at 0, count up by one per written word, and wrap to 0 after 2^OFF_W words. Words are stored in the order in which the FIFO accepted them.
- R4: In a host slot with host_req high, the access uses host_addr (AW bits, the whole memory). With host_we = 1, host_wdata is written. With host_we = 0, the stored word appears on host_rdata with host_rvalid high exactly two cycles after the grant cycle.
- R5: In a channel slot with an empty FIFO and ch_rd_req[k] high, the block reads the word at {1'b0, k, read offset}. The read offset starts at 0 and advances by one per read. The word is returned on ch_rd_data with only ch_rd_valid[k] high, two cycles after the slot.
- R6: In a channel's slot, a non-empty staging FIFO always wins over that channel's read request.
- R7: A word pushed into an empty staging FIFO is written to memory in a slot decided 1 to 8 cycles after the push cycle.
- R8: A FIFO accepts a push when it holds fewer than FIFO_DEPTH words, or when it pops in the same cycle. A push it cannot accept is dropped and sets ch_ovf for that channel, which stays set until reset.
- R9: A slot whose owner has nothing to do leaves sram_we_n and sram_oe_n high in the following cycle.
- R10: sram_we_n and sram_oe_n are never low together, and the address, write data and enables are registered, valid in the cycle after the slot decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_wr_valid | input | NCH | Per-channel incoming word strobe |
| ch_wr_data | input | NCH*DW | Per-channel incoming words, channel k at bits k*DW +: DW |
| ch_rd_req | input | NCH | Per-channel level request for the next sequential read |
| ch_rd_valid | output | NCH | One-hot return strobe for channel reads |
| ch_rd_data | output | DW | Returned channel read word |
| ch_ovf | output | NCH | Sticky staging overflow flags |
| host_req | input | 1 | Host access request, held until granted |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | AW | Host word address |
| host_wdata | input | DW | Host write word |
| host_gnt | output | 1 | Host request taken this cycle |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | DW | Host read word |
| sram_addr | output | AW | Memory word address |
| sram_wdata | output | DW | Memory write data |
| sram_rdata | input | DW | Memory read data |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |

## Verification
The schedule is exercised with a single isolated word, which separates the latency bound from backlog effects. It is also exercised with simultaneous bursts on all four channels, which shows whether each word lands in its owner's slot and region in arrival order. Spaced pushes on one channel drive the offset past its wrap point. A held read request, with writes pushed into the same channel midway, shows the priority of staged writes. Host reads aimed at both a channel region and the host half check the host path. Seven back-to-back pushes into one channel show exactly which words are dropped and that only that channel's flag rises and stays up.

// File: rtl/sram_sched_pkg.sv
package sram_sched_pkg;

  typedef enum logic [2:0] {
    ACC_IDLE    = 3'd0,
    ACC_HOST_WR = 3'd1,
    ACC_HOST_RD = 3'd2,
    ACC_CH_WR   = 3'd3,
    ACC_CH_RD   = 3'd4
  } acc_kind_e;

  // Slot arithmetic: even slots serve the host, slot 2k+1 serves channel k.
  function automatic bit slot_for_host(input int unsigned slot);
    return (slot % 2) == 0;
  endfunction

  function automatic int unsigned slot_channel(input int unsigned slot);
    return slot / 2;
  endfunction

  function automatic int unsigned frame_len(input int unsigned nch);
    return 2 * nch;
  endfunction

endpackage

// File: rtl/slot_ring.sv
module slot_ring #(
  parameter int NCH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic [$clog2(2*NCH)-1:0]   slot,
  output logic                       host_turn,
  output logic [$clog2(NCH)-1:0]     chan
);
  import sram_sched_pkg::*;

  localparam int SLOT_W = $clog2(2*NCH);
  localparam int CH_W   = $clog2(NCH);
  localparam int LAST   = frame_len(NCH) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     slot <= '0;
    else if (slot == SLOT_W'(LAST)) slot <= '0;
    else                            slot <= slot + 1'b1;
  end

  assign host_turn = slot_for_host(32'(slot));
  assign chan      = CH_W'(slot_channel(32'(slot)));

  // R2: host and channel slots alternate
  p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_turn |=> !host_turn);

endmodule

// File: rtl/stage_fifo.sv
module stage_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          ovf
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DW-1:0]    store [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             room, accept, drop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign room   = (cnt != CNT_W'(DEPTH)) || pop;
  assign accept = push && room;
  assign drop   = push && !room;

  always_ff @(posedge clk) begin
    if (accept) store[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (accept) wp <= bump(wp);
      if (pop)    rp <= bump(rp);
      case ({accept, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (drop) ovf <= 1'b1;
    end
  end

  assign head  = store[rp];
  assign empty = (cnt == '0);

  // R8: occupancy never exceeds the depth
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  // R8: overflow flag is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R6: the scheduler only pops a non-empty FIFO
  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/sram_port.sv
module sram_port
  import sram_sched_pkg::*;
#(
  parameter int AW    = 18,
  parameter int DW    = 32,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_kind_e        iss_kind,
  input  logic [AW-1:0]    iss_addr,
  input  logic [DW-1:0]    iss_wdata,
  input  logic [TAG_W-1:0] iss_tag,
  output logic [AW-1:0]    sram_addr,
  output logic [DW-1:0]    sram_wdata,
  output logic             sram_we_n,
  output logic             sram_oe_n,
  input  logic [DW-1:0]    sram_rdata,
  output logic             ret_host,
  output logic             ret_ch,
  output logic [TAG_W-1:0] ret_tag,
  output logic [DW-1:0]    ret_data
);
  logic             s1_host_rd, s1_ch_rd;
  logic [TAG_W-1:0] s1_tag;
  logic             is_wr, is_rd;

  assign is_wr = (iss_kind == ACC_HOST_WR) || (iss_kind == ACC_CH_WR);
  assign is_rd = (iss_kind == ACC_HOST_RD) || (iss_kind == ACC_CH_RD);

  // Stage 1: memory pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr  <= '0;
      sram_wdata <= '0;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      s1_host_rd <= 1'b0;
      s1_ch_rd   <= 1'b0;
      s1_tag     <= '0;
    end else begin
      sram_addr  <= iss_addr;
      sram_wdata <= iss_wdata;
      sram_we_n  <= !is_wr;
      sram_oe_n  <= !is_rd;
      s1_host_rd <= (iss_kind == ACC_HOST_RD);
      s1_ch_rd   <= (iss_kind == ACC_CH_RD);
      s1_tag     <= iss_tag;
    end
  end

  // Stage 2: capture returned word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_host <= 1'b0;
      ret_ch   <= 1'b0;
      ret_tag  <= '0;
      ret_data <= '0;
    end else begin
      ret_host <= s1_host_rd;
      ret_ch   <= s1_ch_rd;
      ret_tag  <= s1_tag;
      if (s1_host_rd || s1_ch_rd) ret_data <= sram_rdata;
    end
  end

  // R10: never write and read at once
  p_bus_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));
  // R4: host return two cycles after a host read was issued
  p_host_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_host |-> $past(iss_kind == ACC_HOST_RD, 2));
  // R5: channel return two cycles after a channel read was issued
  p_ch_ret_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ch |-> $past(iss_kind == ACC_CH_RD, 2));

endmodule

// File: rtl/sram_slot_sched.sv
module sram_slot_sched
  import sram_sched_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int DW         = 32,
  parameter int OFF_W      = 15,
  parameter int FIFO_DEPTH = 4,
  localparam int CH_W      = $clog2(NCH),
  localparam int AW        = OFF_W + CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ch_wr_valid,
  input  logic [NCH*DW-1:0] ch_wr_data,
  input  logic [NCH-1:0]    ch_rd_req,
  output logic [NCH-1:0]    ch_rd_valid,
  output logic [DW-1:0]     ch_rd_data,
  output logic [NCH-1:0]    ch_ovf,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic              host_gnt,
  output logic              host_rvalid,
  output logic [DW-1:0]     host_rdata,
  output logic [AW-1:0]     sram_addr,
  output logic [DW-1:0]     sram_wdata,
  input  logic [DW-1:0]     sram_rdata,
  output logic              sram_we_n,
  output logic              sram_oe_n
);
  localparam int SLOT_W = $clog2(2*NCH);

  logic [SLOT_W-1:0] slot;
  logic              host_turn;
  logic [CH_W-1:0]   cur_ch;

  logic [NCH-1:0]    fifo_pop, fifo_empty, rd_take;
  logic [DW-1:0]     fifo_head [NCH];
  logic [OFF_W-1:0]  wr_off [NCH];
  logic [OFF_W-1:0]  rd_off [NCH];

  acc_kind_e         iss_kind;
  logic [AW-1:0]     iss_addr;
  logic [DW-1:0]     iss_wdata;
  logic              ret_host, ret_ch;
  logic [CH_W-1:0]   ret_tag;
  logic [DW-1:0]     ret_data;

  function automatic logic [AW-1:0] region_word(input logic [CH_W-1:0] ch,
                                                input logic [OFF_W-1:0] off);
    return {1'b0, ch, off};
  endfunction

  slot_ring #(.NCH(NCH)) u_ring (
    .clk(clk), .rst_n(rst_n), .slot(slot), .host_turn(host_turn), .chan(cur_ch)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    stage_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(ch_wr_valid[k]), .push_data(ch_wr_data[k*DW +: DW]),
      .pop(fifo_pop[k]), .head(fifo_head[k]),
      .empty(fifo_empty[k]), .ovf(ch_ovf[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_off[k] <= '0;
        rd_off[k] <= '0;
      end else begin
        if (fifo_pop[k]) wr_off[k] <= wr_off[k] + 1'b1;
        if (rd_take[k])  rd_off[k] <= rd_off[k] + 1'b1;
      end
    end

    // R5: a channel return belongs to that channel's own slot
    p_chrd_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ch_rd_valid[k] |-> ($past(cur_ch, 2) == CH_W'(k)) && !$past(host_turn, 2));
  end

  // Slot decision
  always_comb begin
    iss_kind  = ACC_IDLE;
    iss_addr  = '0;
    iss_wdata = '0;
    fifo_pop  = '0;
    rd_take   = '0;
    if (host_turn) begin
      if (host_req) begin
        iss_kind  = host_we ? ACC_HOST_WR : ACC_HOST_RD;
        iss_addr  = host_addr;
        iss_wdata = host_wdata;
      end
    end else if (!fifo_empty[cur_ch]) begin
      fifo_pop[cur_ch] = 1'b1;
      iss_kind  = ACC_CH_WR;
      iss_addr  = region_word(cur_ch, wr_off[cur_ch]);
      iss_wdata = fifo_head[cur_ch];
    end else if (ch_rd_req[cur_ch]) begin
      rd_take[cur_ch] = 1'b1;
      iss_kind  = ACC_CH_RD;
      iss_addr  = region_word(cur_ch, rd_off[cur_ch]);
    end
  end

  assign host_gnt = host_turn && host_req;

  sram_port #(.AW(AW), .DW(DW), .TAG_W(CH_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .iss_kind(iss_kind), .iss_addr(iss_addr), .iss_wdata(iss_wdata), .iss_tag(cur_ch),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_rdata(sram_rdata),
    .ret_host(ret_host), .ret_ch(ret_ch), .ret_tag(ret_tag), .ret_data(ret_data)
  );

  always_comb begin
    ch_rd_valid = '0;
    if (ret_ch) ch_rd_valid[ret_tag] = 1'b1;
  end

  assign ch_rd_data  = ret_data;
  assign host_rvalid = ret_host;
  assign host_rdata  = ret_data;

  // R4: a grant puts the host address on the memory next cycle
  p_host_gnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |=> (sram_addr == $past(host_addr)) && (sram_we_n != sram_oe_n));
  // R3: channel writes land in the slot owner's region
  p_chan_region_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(host_turn)) |->
      (!sram_addr[AW-1] && (sram_addr[AW-2 -: CH_W] == $past(cur_ch))));
  // R2: host slots and channel slots never both grant
  p_gnt_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_gnt |-> (fifo_pop == '0) && (rd_take == '0));

endmodule

// File: tb/sram_slot_sched_bench.sv
module sram_slot_sched_bench;
  localparam int NCH   = 4;
  localparam int DW    = 32;
  localparam int OFF_W = 3;
  localparam int DEPTH = 4;
  localparam int CH_W  = 2;
  localparam int AW    = OFF_W + CH_W + 1;
  localparam int RW    = 1 << OFF_W;

  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic [NCH-1:0]    ch_wr_valid = '0;
  logic [NCH*DW-1:0] ch_wr_data = '0;
  logic [NCH-1:0]    ch_rd_req = '0;
  logic [NCH-1:0]    ch_rd_valid, ch_ovf;
  logic [DW-1:0]     ch_rd_data;
  logic              host_req = 0, host_we = 0;
  logic [AW-1:0]     host_addr = '0;
  logic [DW-1:0]     host_wdata = '0;
  logic              host_gnt, host_rvalid;
  logic [DW-1:0]     host_rdata;
  logic [AW-1:0]     sram_addr;
  logic [DW-1:0]     sram_wdata;
  logic [DW-1:0]     sram_rdata = '0;
  logic              sram_we_n, sram_oe_n;

  sram_slot_sched #(.NCH(NCH), .DW(DW), .OFF_W(OFF_W), .FIFO_DEPTH(DEPTH)) u_sram_slot_sched (
    .clk(clk), .rst_n(rst_n),
    .ch_wr_valid(ch_wr_valid), .ch_wr_data(ch_wr_data), .ch_rd_req(ch_rd_req),
    .ch_rd_valid(ch_rd_valid), .ch_rd_data(ch_rd_data), .ch_ovf(ch_ovf),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_gnt(host_gnt), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  // Memory model
  logic [DW-1:0] mem [int];
  always @(posedge clk) if (!sram_we_n) mem[int'(sram_addr)] = sram_wdata;
  always @(negedge clk) sram_rdata = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : '0;

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard state
  int n = 0;
  int occ [NCH];
  int wro [NCH];
  int rdo [NCH];
  logic [DW-1:0] fq [NCH][$];
  int            fc [NCH][$];
  bit            fz [NCH][$];
  logic [DW-1:0] refm [int];
  int            hq_c [$];
  logic [DW-1:0] hq_d [$];
  int            cq_c [NCH][$];
  logic [DW-1:0] cq_d [NCH][$];
  logic [NCH-1:0] exp_ovf = '0;
  int ek = 0, ea = 0, edc = 0, eplat = 0;
  bit elat = 0;
  logic [DW-1:0] ed = '0;
  int ms, mc, mp;
  bit mz;

  function automatic logic [DW-1:0] ref_rd(input int a);
    return refm.exists(a) ? refm[a] : '0;
  endfunction

  // Driver-side expectation: decided from the inputs at each edge
  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0;
      for (int c = 0; c < NCH; c++) begin occ[c] = 0; wro[c] = 0; rdo[c] = 0; end
    end else begin
      ms = n % (2*NCH);
      ek = 0; edc = n; elat = 0;
      if (ms % 2 == 0) begin
        if (host_req) begin
          ea = int'(host_addr);
          if (host_we) begin ek = 3; ed = host_wdata; refm[ea] = host_wdata; end
          else begin ek = 4; hq_d.push_back(ref_rd(ea)); hq_c.push_back(n + 2); end
        end
      end else begin
        mc = ms / 2;
        if (occ[mc] > 0) begin
          ek = 1;
          ea = mc * RW + wro[mc];
          ed = fq[mc].pop_front();
          mp = fc[mc].pop_front();
          mz = fz[mc].pop_front();
          elat = mz; eplat = mp;
          refm[ea] = ed;
          wro[mc] = (wro[mc] + 1) % RW;
          occ[mc]--;
        end else if (ch_rd_req[mc]) begin
          ek = 2;
          ea = mc * RW + rdo[mc];
          cq_d[mc].push_back(ref_rd(ea));
          cq_c[mc].push_back(n + 2);
          rdo[mc] = (rdo[mc] + 1) % RW;
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (ch_wr_valid[c]) begin
          if (occ[c] < DEPTH) begin
            fq[c].push_back(ch_wr_data[c*DW +: DW]);
            fc[c].push_back(n);
            fz[c].push_back(occ[c] == 0);
            occ[c]++;
          end else exp_ovf[c] = 1'b1;
        end
      end
      n++;
    end
  end

  // Monitor: compares pins against the queued expectations
  always @(negedge clk) begin
    if (rst_n && n > 0) begin
      case (ek)
        0: chk(sram_we_n && sram_oe_n, "R9 idle slot", {30'd0, sram_we_n, sram_oe_n}, 32'h3);
        1: begin
          chk(!sram_we_n && sram_oe_n && int'(sram_addr) == ea, "R3 channel write addr",
              32'(sram_addr), 32'(ea));
          chk(sram_wdata == ed, "R3 channel write order", sram_wdata, ed);
          if (elat) chk(edc - eplat >= 1 && edc - eplat <= 8, "R7 staging latency",
                        32'(edc - eplat), 32'd8);
        end
        2: chk(!sram_oe_n && sram_we_n && int'(sram_addr) == ea, "R5/R6 channel read addr",
               32'(sram_addr), 32'(ea));
        3: begin
          chk(!sram_we_n && sram_oe_n && int'(sram_addr) == ea, "R4 host write addr",
              32'(sram_addr), 32'(ea));
          chk(sram_wdata == ed, "R4 host write data", sram_wdata, ed);
        end
        default: chk(!sram_oe_n && sram_we_n && int'(sram_addr) == ea, "R4 host read addr",
                     32'(sram_addr), 32'(ea));
      endcase
      // R10: never both enables low
      chk(sram_we_n || sram_oe_n, "R10 bus exclusive", {30'd0, sram_we_n, sram_oe_n}, 32'h1);
      // R4 host returns
      if (host_rvalid) begin
        if (hq_c.size() == 0) chk(0, "R4 unexpected host_rvalid", 32'd1, 32'd0);
        else begin
          chk(hq_c[0] == n, "R4 host return cycle", 32'(n), 32'(hq_c[0]));
          chk(host_rdata == hq_d[0], "R4 host read data", host_rdata, hq_d[0]);
          void'(hq_c.pop_front()); void'(hq_d.pop_front());
        end
      end else if (hq_c.size() > 0 && hq_c[0] <= n)
        chk(0, "R4 missing host_rvalid", 32'd0, 32'd1);
      // R5 channel returns
      chk($countones(ch_rd_valid) <= 1, "R5 one-hot return", 32'(ch_rd_valid), 32'd0);
      for (int c = 0; c < NCH; c++) begin
        if (ch_rd_valid[c]) begin
          if (cq_c[c].size() == 0) chk(0, "R5 unexpected ch_rd_valid", 32'(c), 32'hff);
          else begin
            chk(cq_c[c][0] == n, "R5 channel return cycle", 32'(n), 32'(cq_c[c][0]));
            chk(ch_rd_data == cq_d[c][0], "R5 channel read data", ch_rd_data, cq_d[c][0]);
            void'(cq_c[c].pop_front()); void'(cq_d[c].pop_front());
          end
        end else if (cq_c[c].size() > 0 && cq_c[c][0] <= n)
          chk(0, "R5 missing ch_rd_valid", 32'(c), 32'(cq_c[c][0]));
      end
      // R8 overflow flags
      chk(ch_ovf == exp_ovf, "R8 overflow flags", 32'(ch_ovf), 32'(exp_ovf));
    end
  end

  // Driver tasks
  task automatic push_one(input int c, input logic [DW-1:0] d);
    @(negedge clk);
    ch_wr_valid[c] = 1'b1;
    ch_wr_data[c*DW +: DW] = d;
    @(negedge clk);
    ch_wr_valid[c] = 1'b0;
  endtask

  task automatic idle(input int cyc);
    repeat (cyc) @(negedge clk);
  endtask

  task automatic host_op(input bit we, input int a, input logic [DW-1:0] d);
    int waited;
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = AW'(a); host_wdata = d;
    waited = 0;
    forever begin
      #1;
      if (host_gnt) break;
      waited++;
      @(negedge clk);
    end
    chk(n % 2 == 0, "R2 host_gnt in host slot", 32'(n), 32'd0);
    chk(waited <= 1, "R2 host wait bound", 32'(waited), 32'd1);
    @(negedge clk);
    host_req = 0;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(sram_we_n && sram_oe_n, "R1 enables high in reset", {30'd0, sram_we_n, sram_oe_n}, 32'h3);
    chk(!host_rvalid && ch_rd_valid == '0, "R1 no returns in reset", 32'(ch_rd_valid), 32'd0);
    chk(ch_ovf == '0 && !host_gnt, "R1 flags clear in reset", 32'(ch_ovf), 32'd0);
    rst_n = 1;
    #1;
    chk(sram_we_n && sram_oe_n && ch_ovf == '0, "R1 state after reset",
        {30'd0, sram_we_n, sram_oe_n}, 32'h3);

    // Isolated word: latency bound (R7)
    push_one(0, 32'hA000_0001);
    idle(12);

    // Simultaneous bursts on every channel (R2, R3)
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        ch_wr_valid[c] = 1'b1;
        ch_wr_data[c*DW +: DW] = 32'hB000_0000 | (c << 8) | w;
      end
    end
    @(negedge clk);
    ch_wr_valid = '0;
    idle(40);

    // Host path (R4), including a word inside channel 0's region (R3)
    host_op(1, 32 + 1, 32'hC0DE_0021);
    host_op(1, 32 + 10, 32'hC0DE_002A);
    host_op(0, 32 + 1, '0);
    host_op(0, 0, '0);
    host_op(0, 2*RW + 2, '0);
    idle(6);

    // Held reads with writes pushed midway (R5, R6)
    @(negedge clk);
    ch_rd_req[1] = 1'b1; ch_rd_req[2] = 1'b1;
    idle(15);
    push_one(1, 32'hD100_0001);
    push_one(1, 32'hD100_0002);
    idle(30);
    ch_rd_req = '0;
    idle(6);

    // Spaced pushes on channel 0 to wrap its offset (R3)
    for (int w = 0; w < 10; w++) begin
      push_one(0, 32'hE000_0000 | w);
      idle(8);
    end
    idle(10);

    // Burst overflow on channel 3 (R8)
    @(negedge clk);
    for (int w = 0; w < 7; w++) begin
      ch_wr_valid[3] = 1'b1;
      ch_wr_data[3*DW +: DW] = 32'hF300_0000 | w;
      @(negedge clk);
    end
    ch_wr_valid[3] = 1'b0;
    #1;
    chk(ch_ovf == 4'b1000, "R8 only channel 3 flagged", 32'(ch_ovf), 32'h8);
    idle(60);
    #1;
    chk(ch_ovf == 4'b1000, "R8 flag stays set", 32'(ch_ovf), 32'h8);
    chk(occ[3] == 0, "R8 accepted words drained", 32'(occ[3]), 32'd0);

    chk(hq_c.size() == 0, "R4 all host reads returned", 32'(hq_c.size()), 32'd0);
    for (int c = 0; c < NCH; c++)
      chk(cq_c[c].size() == 0, "R5 all channel reads returned", 32'(cq_c[c].size()), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule